// File: doc/BRIEF.md
# Memory Test Traffic Generator

This block runs by itself after reset and drives a memory-mapped master port so that a memory interface gets exercised. Every operation is a write group, either one beat or a burst, followed by a read of exactly the same locations. For every write beat it accepts, it pushes the expected read word into a queue. A separate checker consumes that queue and compares it with the returned read data.

The work is split into a fixed schedule of six subphases. There is a single-beat phase, followed by a burst phase. Each phase runs its sequential-address, random-address and mixed subphases in that order. The number of operations in each subphase and the burst length window of each burst subphase are parameters. In the mixed subphases, a threshold parameter sets how often an operation takes the next sequential address instead of a random one. When the schedule is exhausted, the block waits for the checker to report that all reads have drained. It then settles in a pass or fail state, chosen from the checker's error flag.

Top module: `mem_traffic_gen`

## Requirements
- R1: While rst_ni is low, no write or read is requested, no expected word is pushed, and neither pass_o nor fail_o is high.
- R2: Each operation writes burstcount beats at one base address (address and burstcount held for all beats). It then issues a single read request with the same address and burstcount. That read is requested only after the last write beat has been accepted.
- R3: Write beat i of operation k (k counted from 0 after reset) carries, in every 32-bit lane, the value {k[15:0], (base+i)[15:0]}. The address sum wraps at the address width.
- R4: exp_valid_o is high exactly in the cycles where a write beat is accepted (write high, waitrequest low), and exp_data_o then equals that beat's write data.
- R5: While waitrequest is high, a pending write or read keeps its request, address, burstcount and write data unchanged into the next cycle.
- R6: Subphases run in the order single/sequential, single/random, single/mixed, burst/sequential, burst/random, burst/mixed. Each runs its parameterized number of operations, and a count of zero skips it. Every single-phase operation has burstcount 1.
- R7: A sequential operation takes its base from a pointer that is 0 after reset. After every sequentially addressed operation, in any subphase, the pointer advances by that operation's burstcount.
- R8: The burstcount of every burst-phase operation lies within the minimum and maximum configured for its subphase.
- R9: In a mixed subphase, an operation is sequential when the low 8 bits of a 32-bit LFSR are below MIX_SEQ_THR. A threshold of 256 makes every mixed operation sequential, and 0 makes every one random.
- R10: After the final operation, no further requests are made. pass_o or fail_o rises only after chk_drained_i is seen high, and chk_error_i at that moment selects fail. The state then holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| avm_address_o | output | AW | Base word address of the current request |
| avm_write_o | output | 1 | Write request |
| avm_read_o | output | 1 | Read request |
| avm_writedata_o | output | DW | Write data for the current beat |
| avm_burstcount_o | output | BCW | Beats in the current operation |
| avm_waitrequest_i | input | 1 | Slave stall; the request is not taken while high |
| exp_valid_o | output | 1 | Push strobe into the expected-data queue |
| exp_data_o | output | DW | Expected read word |
| chk_drained_i | input | 1 | Checker has compared every outstanding read |
| chk_error_i | input | 1 | Checker has seen a mismatch |
| pass_o | output | 1 | Terminal pass state |
| fail_o | output | 1 | Terminal fail state |

## Verification
The mixed subphase is the hardest part to observe from the ports, because its address choice depends on LFSR bits that are not visible. The bench therefore sets the threshold to 256 and the single/random count to zero. Every mixed operation must then continue the sequential pointer directly after the single/sequential ones, which also proves that the empty subphase was skipped. A waitrequest that toggles at random on every cycle stalls beats in the middle of bursts and stalls read commands, so that hold behaviour and the write-to-read switch are exercised across many stall positions.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  typedef enum logic [2:0] {
    ST_PLAN, ST_WR, ST_RD, ST_DRAIN, ST_PASS, ST_FAIL
  } mtg_state_e;

  localparam int NSUB = 6;
  localparam int SUB_W = $clog2(NSUB + 1);
endpackage

// File: rtl/mtg_lfsr.sv
module mtg_lfsr #(
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  output logic [31:0] state_o
);
  logic [31:0] q;
  // x^32 + x^22 + x^2 + x + 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= SEED;
    else if (adv_i) q <= {q[30:0], q[31] ^ q[21] ^ q[1] ^ q[0]};
  end
  assign state_o = q;

  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) q != 32'd0);
endmodule

// File: rtl/mtg_sched.sv
module mtg_sched import mtg_pkg::*; #(
  parameter int CW = 16,
  parameter logic [NSUB-1:0][CW-1:0] CNTS = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SUB_W-1:0] sub_o,
  output logic             done_o
);
  logic [SUB_W-1:0] sub_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [SUB_W-1:0] first_nz(int start);
    logic [SUB_W-1:0] r;
    r = SUB_W'(NSUB);
    for (int i = NSUB - 1; i >= 0; i--)
      if (i >= start && CNTS[i] != '0) r = SUB_W'(i);
    return r;
  endfunction

  assign done_o = (sub_q == SUB_W'(NSUB));
  assign sub_o  = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= first_nz(0);
      cnt_q <= '0;
    end else if (adv_i && !done_o) begin
      if (cnt_q + CW'(1) == CNTS[sub_q]) begin
        sub_q <= first_nz(int'(sub_q) + 1);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R6
  sched_done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> done_o);
  // R6
  sched_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !$stable(sub_q) |-> sub_q > $past(sub_q));
endmodule

// File: rtl/mem_traffic_gen.sv
module mem_traffic_gen import mtg_pkg::*; #(
  parameter int          AW          = 16,
  parameter int          DW          = 32,
  parameter int          BCW         = 4,
  parameter int unsigned CNT_IS      = 4,
  parameter int unsigned CNT_IR      = 3,
  parameter int unsigned CNT_IM      = 3,
  parameter int unsigned CNT_BS      = 3,
  parameter int unsigned CNT_BR      = 3,
  parameter int unsigned CNT_BM      = 3,
  parameter int          BS_MIN      = 2,
  parameter int          BS_MAX      = 4,
  parameter int          BR_MIN      = 1,
  parameter int          BR_MAX      = 8,
  parameter int          BM_MIN      = 3,
  parameter int          BM_MAX      = 6,
  parameter int          MIX_SEQ_THR = 128,
  parameter logic [31:0] SEED        = 32'hACE1_2468
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [AW-1:0]  avm_address_o,
  output logic           avm_write_o,
  output logic           avm_read_o,
  output logic [DW-1:0]  avm_writedata_o,
  output logic [BCW-1:0] avm_burstcount_o,
  input  logic           avm_waitrequest_i,
  output logic           exp_valid_o,
  output logic [DW-1:0]  exp_data_o,
  input  logic           chk_drained_i,
  input  logic           chk_error_i,
  output logic           pass_o,
  output logic           fail_o
);
  localparam int CW    = 16;
  localparam int LANES = DW / 32;
  localparam logic [NSUB-1:0][CW-1:0] CNTS = {CW'(CNT_BM), CW'(CNT_BR), CW'(CNT_BS),
                                              CW'(CNT_IM), CW'(CNT_IR), CW'(CNT_IS)};

  mtg_state_e       state_q;
  logic [AW-1:0]    base_q, seq_ptr_q, plan_base;
  logic [BCW-1:0]   len_q, beat_q, plan_len;
  logic [CW-1:0]    opcnt_q;
  logic [31:0]      lfsr;
  logic [SUB_W-1:0] sub;
  logic             sched_done, plan_go, plan_seq, wr_acc, rd_acc;

  function automatic logic [DW-1:0] beat_data(logic [AW-1:0] a, logic [CW-1:0] k);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*32 +: 32] = {k[15:0], 16'(a)};
    return r;
  endfunction

  assign plan_go = (state_q == ST_PLAN) && !sched_done;
  assign wr_acc  = avm_write_o && !avm_waitrequest_i;
  assign rd_acc  = avm_read_o && !avm_waitrequest_i;

  mtg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(plan_go), .state_o(lfsr)
  );

  mtg_sched #(.CW(CW), .CNTS(CNTS)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rd_acc), .sub_o(sub), .done_o(sched_done)
  );

  always_comb begin
    int lo, hi, k;
    k  = int'(sub) % 3;
    lo = 1;
    hi = 1;
    case (int'(sub))
      3:       begin lo = BS_MIN; hi = BS_MAX; end
      4:       begin lo = BR_MIN; hi = BR_MAX; end
      5:       begin lo = BM_MIN; hi = BM_MAX; end
      default: ;
    endcase
    plan_seq  = (k == 0) || (k == 2 && ({1'b0, lfsr[7:0]} < 9'(MIX_SEQ_THR)));
    plan_len  = BCW'(lo + (int'(lfsr[23:16]) % (hi - lo + 1)));
    plan_base = plan_seq ? seq_ptr_q : AW'(lfsr ^ (lfsr >> 16));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PLAN;
      base_q    <= '0;
      len_q     <= '0;
      beat_q    <= '0;
      opcnt_q   <= '0;
      seq_ptr_q <= '0;
    end else begin
      case (state_q)
        ST_PLAN: begin
          if (sched_done) begin
            state_q <= ST_DRAIN;
          end else begin
            base_q  <= plan_base;
            len_q   <= plan_len;
            beat_q  <= '0;
            state_q <= ST_WR;
            if (plan_seq) seq_ptr_q <= seq_ptr_q + AW'(plan_len);
          end
        end
        ST_WR: if (wr_acc) begin
          beat_q <= beat_q + BCW'(1);
          if (beat_q + BCW'(1) == len_q) state_q <= ST_RD;
        end
        ST_RD: if (rd_acc) begin
          opcnt_q <= opcnt_q + CW'(1);
          state_q <= ST_PLAN;
        end
        ST_DRAIN: if (chk_drained_i) state_q <= chk_error_i ? ST_FAIL : ST_PASS;
        default: ;
      endcase
    end
  end

  assign avm_write_o      = (state_q == ST_WR);
  assign avm_read_o       = (state_q == ST_RD);
  assign avm_address_o    = base_q;
  assign avm_burstcount_o = len_q;
  assign avm_writedata_o  = beat_data(base_q + AW'(beat_q), opcnt_q);
  assign exp_valid_o      = wr_acc;
  assign exp_data_o       = avm_writedata_o;
  assign pass_o           = (state_q == ST_PASS);
  assign fail_o           = (state_q == ST_FAIL);

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avm_write_o && avm_waitrequest_i |=> avm_write_o && $stable(avm_address_o)
      && $stable(avm_writedata_o) && $stable(avm_burstcount_o));
  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avm_read_o && avm_waitrequest_i |=> avm_read_o && $stable(avm_address_o)
      && $stable(avm_burstcount_o));
  // R2
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avm_read_o) |-> $past(avm_write_o && !avm_waitrequest_i));
  // R2
  wr_bc_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avm_write_o |-> avm_burstcount_o != '0);
  // R10
  pass_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> $past(chk_drained_i && !chk_error_i));
  // R10
  fail_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(chk_drained_i && chk_error_i));
  // R10
  pass_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pass_o |=> pass_o);
  // R10
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fail_o |=> fail_o);
endmodule

// File: tb/sim_mem_traffic_gen.sv
module sim_mem_traffic_gen;
  localparam int AW = 16, DW = 32, BCW = 4;
  localparam int IS = 4, IR = 0, IM = 3, BS = 3, BR = 3, BM = 3;
  localparam int TOTAL = IS + IR + IM + BS + BR + BM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic wr, rd, waitreq = 1'b0, ev, drained = 1'b0, cerr = 1'b0, pass, fail;
  logic [DW-1:0] wd, ed;
  logic [BCW-1:0] bc;
  int errs = 0, checks = 0;
  int opidx = 0, beat = 0, cur_base = 0, cur_len = 0, prev_base = 0, prev_len = 0;
  bit held_w = 0, held_r = 0;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wd;
  logic [BCW-1:0] s_bc;

  always #5 clk = ~clk;

  mem_traffic_gen #(
    .AW(AW), .DW(DW), .BCW(BCW), .CNT_IS(IS), .CNT_IR(IR), .CNT_IM(IM),
    .CNT_BS(BS), .CNT_BR(BR), .CNT_BM(BM), .BS_MIN(2), .BS_MAX(4),
    .BR_MIN(1), .BR_MAX(8), .BM_MIN(3), .BM_MAX(6), .MIX_SEQ_THR(256)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .avm_address_o(addr), .avm_write_o(wr), .avm_read_o(rd),
    .avm_writedata_o(wd), .avm_burstcount_o(bc), .avm_waitrequest_i(waitreq),
    .exp_valid_o(ev), .exp_data_o(ed), .chk_drained_i(drained), .chk_error_i(cerr),
    .pass_o(pass), .fail_o(fail)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_data(int a, int k);
    return {16'(k), 16'(a)};
  endfunction

  // stimulus on waitrequest and port monitor
  always @(negedge clk) begin
    waitreq = rst_n ? 1'($urandom_range(0, 1)) : 1'b0;
    #1;
    if (!rst_n) begin
      opidx = 0; beat = 0; held_w = 0; held_r = 0; prev_base = 0; prev_len = 0;
    end else begin
      if (held_w) chk(wr && addr == s_addr && wd == s_wd && bc == s_bc, "R5 write hold", longint'(wd), longint'(s_wd));
      if (held_r) chk(rd && addr == s_addr && bc == s_bc, "R5 read hold", longint'(addr), longint'(s_addr));
      held_w = wr && waitreq;
      held_r = rd && waitreq;
      s_addr = addr; s_wd = wd; s_bc = bc;
      if (wr && !waitreq) begin
        if (beat == 0) begin cur_base = int'(addr); cur_len = int'(bc); end
        chk(int'(addr) == cur_base && int'(bc) == cur_len, "R2 burst base", longint'(addr), longint'(cur_base));
        chk(wd == model_data((cur_base + beat) % (1 << AW), opidx), "R3 write data",
            longint'(wd), longint'(model_data((cur_base + beat) % (1 << AW), opidx)));
        chk(ev && ed == wd, "R4 expected push", longint'(ed), longint'(wd));
        beat++;
      end else begin
        chk(!ev, "R4 no push", longint'(ev), 0);
      end
      if (rd && !waitreq) begin
        chk(beat == cur_len && int'(addr) == cur_base && int'(bc) == cur_len,
            "R2 read matches write", longint'(beat), longint'(cur_len));
        if (opidx < IS + IM) begin
          chk(cur_len == 1, "R6 single beat", longint'(cur_len), 1);
          // R7 for sequential subphase, R9 for mixed with threshold 256
          chk(cur_base == opidx, opidx < IS ? "R7 seq base" : "R9 mixed seq",
              longint'(cur_base), longint'(opidx));
        end else begin
          int j, lo, hi;
          j = opidx - (IS + IM);
          if (j < BS) begin
            lo = 2; hi = 4;
            chk(cur_base == (prev_base + prev_len) % (1 << AW), "R7 burst seq base",
                longint'(cur_base), longint'(prev_base + prev_len));
          end else if (j < BS + BR) begin lo = 1; hi = 8; end
          else begin lo = 3; hi = 6; end
          chk(cur_len >= lo && cur_len <= hi, "R8 burst range", longint'(cur_len), longint'(lo));
        end
        prev_base = cur_base; prev_len = cur_len;
        opidx++; beat = 0;
      end
      if (pass || fail) chk(!wr && !rd, "R10 idle at end", longint'({wr, rd}), 0);
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic run(bit with_err);
    int w;
    cerr = with_err; drained = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!wr && !rd && !ev && !pass && !fail, "R1 reset idle", longint'({wr, rd, ev, pass, fail}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    w = 0;
    while (opidx < TOTAL && w < 20000) begin @(posedge clk); w++; end
    repeat (10) @(negedge clk);
    #2;
    chk(opidx == TOTAL, "R6 op count", longint'(opidx), longint'(TOTAL));
    chk(!pass && !fail, "R10 waits for drain", longint'({pass, fail}), 0);
    chk(!wr && !rd, "R10 no requests after schedule", longint'({wr, rd}), 0);
    drained = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(pass == !with_err && fail == with_err, "R10 verdict", longint'({pass, fail}), longint'({!with_err, with_err}));
    drained = 1'b0; cerr = ~with_err;
    repeat (5) @(negedge clk);
    #2;
    chk(pass == !with_err && fail == with_err, "R10 verdict holds", longint'({pass, fail}), longint'({!with_err, with_err}));
  endtask

  initial begin
    void'($urandom(32'd2024));
    run(1'b0);
    run(1'b1);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule